// File: doc/BRIEF.md
# Banked Vectored Interrupt Controller

This block collects raw, active-low interrupt lines that are grouped in banks of 32. It presents them to a processor as two request outputs, a normal request and a fast request. Each line has a configuration word with three fields: a five-bit priority, a sense type (falling edge or low level) and a route (normal or fast). Lines latch into a per-bank pending register. A per-bank mask register gates them, and a write-only register lets software raise lines directly.

Each request class has an arm flag. An output rises only while its class is armed and some pending, unmasked line is routed to it. When the output rises, the arm flag clears and the winning line number is latched into that class's source-code register. Software reads the source-code register to find the line. That read also acknowledges the line, but only when the line is edge-sensed. Software then writes the control register to drop the output and re-arm the class. The class is evaluated again on the following cycle. Priority 0 is the most urgent. When priorities are equal, the higher line number wins.

Register access is a simple full-word bus. The read data is combinational for the addressed word, and read side effects take place on the clock edge while the read strobe is high. Address bits [9:8] select the bank, and bits [7:2] select the word. Bits [1:0] are ignored. The address layout allows at most four banks and at most 57 lines per bank.

Top module: `irq_hub`

## Requirements
- R1: After reset both outputs are low and both classes are armed. All pending bits, sense bits, route bits and priorities are 0, every mask bit is 1, and both source codes read 0.
- R2: The configuration word of line n in bank b is at address b*0x100 + 0x1C + 4*n. Bits [6:2] hold the priority, bit 1 the sense type and bit 0 the route. Writes store only these bits, and reads return them with all other bits 0.
- R3: The sense bit 0 selects falling-edge sensing. An edge-sensed line becomes pending only on a new assertion, which is a high-to-low change of its line_n input. Holding the input low does not make it pending again once it has been cleared.
- R4: The sense bit 1 selects low-level sensing. A level-sensed line becomes pending when it is asserted, and it stays pending while asserted: neither a clearing write nor a source-code read removes it. It leaves the pending state when its input returns high.
- R5: The pending register is at word offset 0x00 of each bank. Writing to it clears every bit written as 0 and leaves bits written as 1 unchanged.
- R6: The mask register is at offset 0x04 of each bank, and a mask bit of 1 masks the line. A masked line can be pending and can be seen in the pending register, but it never raises an output.
- R7: Writing 1s to offset 0x08 of a bank makes the matching lines pending, as if they had been asserted. Reads of offset 0x08 return 0.
- R8: An output rises on the clock edge after its class is armed and at least one pending, unmasked line is routed to it. On that same edge the class is disarmed and the winning global line number (32*bank + line) is latched. The output then stays high until the class is re-armed, even if the pending bit is cleared.
- R9: The winner is the candidate with the lowest priority value. When priorities are equal, the higher global line number wins.
- R10: Reading bank-0 offset 0x10 returns the latched normal-class line, and reading offset 0x14 returns the latched fast-class line. The read clears that line's pending bit only if the line is edge-sensed.
- R11: Bank-0 offset 0x18 is the control register. Writing bit 0 as 1 drops the normal output and re-arms that class, and writing bit 1 as 1 does the same for the fast class. A re-armed class can rise again on the next clock edge. A class whose bit is written as 0 is not affected.
- R12: Reads return 0 in these cases: a bank number at or above NBANK, an undefined offset, a configuration offset past the last line, and the code or control offsets in any bank other than 0. Writes to these addresses have no effect.
- R13: A route bit of 1 sends the line to the fast output, and a route bit of 0 sends it to the normal output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_n | input | NBANK*32 | Raw interrupt lines, active low, line 32*b+i is bank b bit i |
| bus_addr | input | 10 | Byte address of the register word |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, side effects take place on the edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word |
| irq_o | output | 1 | Normal-class interrupt request |
| fiq_o | output | 1 | Fast-class interrupt request |

## Verification
The hardest situation to reach is several candidates present at one evaluation, because the first unmasked candidate fires at once and disarms its class. To get there, the stimulus fires one line and leaves that class disarmed. It then raises several more lines through the software-raise register, so they all wait for the re-arm. Each acknowledge and re-arm cycle then shows the next winner: a tie decided by line number, and then a lower-priority line. A second hard case is telling the acknowledge rules apart. A level-sensed line is held low across a source-code read and a clearing write, and the bench then checks that its pending bit survives both.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

  localparam int PRIO_W = 5;

  // Per-line configuration word, packed so that bit 0 is the route,
  // bit 1 the sense type and bits [6:2] the priority.
  typedef struct packed {
    logic [PRIO_W-1:0] prio;
    logic              level;   // 1: low level, 0: falling edge
    logic              to_fiq;  // 1: fast class, 0: normal class
  } line_cfg_t;

  localparam int CFG_W = $bits(line_cfg_t);

  // Word indices inside one bank (byte offset >> 2)
  localparam logic [5:0] W_PEND = 6'd0;
  localparam logic [5:0] W_MASK = 6'd1;
  localparam logic [5:0] W_SOFT = 6'd2;
  localparam logic [5:0] W_IRQC = 6'd4;
  localparam logic [5:0] W_FIQC = 6'd5;
  localparam logic [5:0] W_CTRL = 6'd6;
  localparam logic [5:0] W_CFG0 = 6'd7;

endpackage

// File: rtl/irq_hub_bank.sv
module irq_hub_bank
  import irq_hub_pkg::*;
#(
  parameter int LINES = 32,
  parameter int IDX_W = $clog2(LINES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LINES-1:0]        line_n,
  input  logic                    pend_we,
  input  logic                    mask_we,
  input  logic                    soft_we,
  input  logic                    cfg_we,
  input  logic [IDX_W-1:0]        cfg_idx,
  input  line_cfg_t               cfg_wr,
  input  logic [LINES-1:0]        wdata,
  input  logic [LINES-1:0]        ack,
  output logic [LINES-1:0]        pending_o,
  output logic [LINES-1:0]        mask_o,
  output line_cfg_t [LINES-1:0]   cfg_o
);

  logic [LINES-1:0] pend_q, pend_d;
  logic [LINES-1:0] mask_q, mask_d;
  logic [LINES-1:0] prev_q;
  logic [LINES-1:0] asserted, level_v, soft_set;
  logic [LINES-1:0] wr_clr, ack_clr, drop_clr, cfg_we_v;
  line_cfg_t [LINES-1:0] cfg_q;

  assign asserted = ~line_n;
  assign soft_set = soft_we ? wdata : '0;

  always_comb begin
    for (int i = 0; i < LINES; i++) begin
      level_v[i]  = cfg_q[i].level;
      cfg_we_v[i] = cfg_we && (cfg_idx == IDX_W'(i));
    end
  end

  // Clearing sources; a level line that is still low resists all of them
  assign wr_clr   = pend_we ? (~wdata & ~(level_v & asserted)) : '0;
  assign ack_clr  = ack & ~level_v;
  assign drop_clr = level_v & prev_q & ~asserted;

  // Next state: a setting event in the same cycle wins over any clear
  always_comb begin
    pend_d = (pend_q & ~(wr_clr | ack_clr | drop_clr))
           | (asserted & ~prev_q) | soft_set;
    mask_d = mask_we ? wdata : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '1;
      prev_q <= '0;
    end else begin
      pend_q <= pend_d;
      mask_q <= mask_d;
      prev_q <= asserted;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (cfg_we_v[i]) cfg_q[i] <= cfg_wr;
      end
    end
  end

  assign pending_o = pend_q;
  assign mask_o    = mask_q;
  assign cfg_o     = cfg_q;

  // R3
  pend_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q)) & ~($past(~line_n) & ~$past(prev_q))
      & ~$past(soft_set)) == '0);

  // R4
  level_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & $past(level_v & prev_q & line_n) & ~$past(soft_set)) == '0);

  // R4
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(level_v & ~line_n & prev_q & pend_q) & ~pend_q) == '0);

endmodule

// File: rtl/irq_hub_pick.sv
module irq_hub_pick
  import irq_hub_pkg::*;
#(
  parameter int N      = 64,
  parameter int CODE_W = $clog2(N)
) (
  input  logic [N-1:0]             cand,
  input  logic [N-1:0][PRIO_W-1:0] prio,
  output logic                     any,
  output logic [CODE_W-1:0]        win
);

  logic [PRIO_W-1:0] best;

  // Ascending scan; "<=" lets a later (higher) line take a tie
  always_comb begin
    any  = 1'b0;
    win  = '0;
    best = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!any || (prio[i] <= best))) begin
        any  = 1'b1;
        best = prio[i];
        win  = CODE_W'(i);
      end
    end
  end

endmodule

// File: rtl/irq_hub_gate.sv
module irq_hub_gate #(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cand_any,
  input  logic [CODE_W-1:0] win,
  input  logic              rearm,
  output logic              out_o,
  output logic [CODE_W-1:0] code_o
);

  logic              armed_q, armed_d;
  logic              out_q, out_d;
  logic [CODE_W-1:0] code_q, code_d;

  always_comb begin
    armed_d = armed_q;
    out_d   = out_q;
    code_d  = code_q;
    if (rearm) begin
      armed_d = 1'b1;
      out_d   = 1'b0;
    end else if (armed_q && cand_any) begin
      armed_d = 1'b0;
      out_d   = 1'b1;
      code_d  = win;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      out_q   <= 1'b0;
      code_q  <= '0;
    end else begin
      armed_q <= armed_d;
      out_q   <= out_d;
      code_q  <= code_d;
    end
  end

  assign out_o  = out_q;
  assign code_o = code_q;

  // R8
  armed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> !out_q);

  // R8
  fire_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_q) |-> ($past(cand_any) && $past(armed_q)));

  // R11
  rearm_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> !out_q);

endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int NBANK  = 2,
  parameter int LINES  = 32,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NBANK*LINES-1:0] line_n,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic [DATA_W-1:0]      bus_rdata,
  output logic                   irq_o,
  output logic                   fiq_o
);

  localparam int NLINE  = NBANK * LINES;
  localparam int CODE_W = $clog2(NLINE);
  localparam int IDX_W  = $clog2(LINES);
  localparam int BSEL_W = ADDR_W - 8;

  logic [BSEL_W-1:0] bank_sel;
  logic [5:0]        word, cfg_word;
  logic [IDX_W-1:0]  cfg_idx;
  logic              cfg_hit, bank0;
  line_cfg_t         cfg_wr;

  assign bank_sel = bus_addr[ADDR_W-1:8];
  assign word     = bus_addr[7:2];
  assign cfg_word = word - W_CFG0;
  assign cfg_idx  = cfg_word[IDX_W-1:0];
  assign cfg_hit  = (word >= W_CFG0) && (int'(word) < int'(W_CFG0) + LINES);
  assign bank0    = (bank_sel == '0);
  assign cfg_wr   = line_cfg_t'(bus_wdata[CFG_W-1:0]);

  logic [NLINE-1:0]             pend_all, mask_all, ack_all, route_v;
  logic [NLINE-1:0]             cand_irq, cand_fiq;
  line_cfg_t [NLINE-1:0]        cfg_all;
  logic [NLINE-1:0][PRIO_W-1:0] prio_v;

  logic              irq_any, fiq_any, irq_ack, fiq_ack, ctrl_we;
  logic [CODE_W-1:0] irq_win, fiq_win, irq_code, fiq_code;

  assign irq_ack = bus_rd && bank0 && (word == W_IRQC);
  assign fiq_ack = bus_rd && bank0 && (word == W_FIQC);
  assign ctrl_we = bus_wr && bank0 && (word == W_CTRL);

  assign ack_all = (irq_ack ? (NLINE'(1) << irq_code) : '0)
                 | (fiq_ack ? (NLINE'(1) << fiq_code) : '0);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit;
    assign hit = (int'(bank_sel) == b);

    irq_hub_bank #(.LINES(LINES), .IDX_W(IDX_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_n    (line_n[b*LINES +: LINES]),
      .pend_we   (bus_wr && hit && (word == W_PEND)),
      .mask_we   (bus_wr && hit && (word == W_MASK)),
      .soft_we   (bus_wr && hit && (word == W_SOFT)),
      .cfg_we    (bus_wr && hit && cfg_hit),
      .cfg_idx   (cfg_idx),
      .cfg_wr    (cfg_wr),
      .wdata     (bus_wdata[LINES-1:0]),
      .ack       (ack_all[b*LINES +: LINES]),
      .pending_o (pend_all[b*LINES +: LINES]),
      .mask_o    (mask_all[b*LINES +: LINES]),
      .cfg_o     (cfg_all[b*LINES +: LINES])
    );
  end

  always_comb begin
    for (int i = 0; i < NLINE; i++) begin
      route_v[i] = cfg_all[i].to_fiq;
      prio_v[i]  = cfg_all[i].prio;
    end
  end

  assign cand_irq = pend_all & ~mask_all & ~route_v;
  assign cand_fiq = pend_all & ~mask_all & route_v;

  irq_hub_pick #(.N(NLINE), .CODE_W(CODE_W)) u_pick_irq (
    .cand (cand_irq),
    .prio (prio_v),
    .any  (irq_any),
    .win  (irq_win)
  );

  irq_hub_pick #(.N(NLINE), .CODE_W(CODE_W)) u_pick_fiq (
    .cand (cand_fiq),
    .prio (prio_v),
    .any  (fiq_any),
    .win  (fiq_win)
  );

  irq_hub_gate #(.CODE_W(CODE_W)) u_gate_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .cand_any (irq_any),
    .win      (irq_win),
    .rearm    (ctrl_we && bus_wdata[0]),
    .out_o    (irq_o),
    .code_o   (irq_code)
  );

  irq_hub_gate #(.CODE_W(CODE_W)) u_gate_fiq (
    .clk      (clk),
    .rst_n    (rst_n),
    .cand_any (fiq_any),
    .win      (fiq_win),
    .rearm    (ctrl_we && bus_wdata[1]),
    .out_o    (fiq_o),
    .code_o   (fiq_code)
  );

  // Read mux for the addressed word
  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (int'(bank_sel) == b) begin
        if (word == W_PEND) begin
          bus_rdata = DATA_W'(pend_all[b*LINES +: LINES]);
        end else if (word == W_MASK) begin
          bus_rdata = DATA_W'(mask_all[b*LINES +: LINES]);
        end else if (cfg_hit) begin
          bus_rdata = DATA_W'(cfg_all[b*LINES + int'(cfg_idx)]);
        end else if (b == 0 && word == W_IRQC) begin
          bus_rdata = DATA_W'(irq_code);
        end else if (b == 0 && word == W_FIQC) begin
          bus_rdata = DATA_W'(fiq_code);
        end
      end
    end
  end

  logic unused_bits;
  assign unused_bits = ^{bus_addr[1:0], cfg_word, bus_wdata};

  // R9
  irq_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any |-> cand_irq[irq_win]);

  // R9
  fiq_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_any |-> cand_fiq[fiq_win]);

endmodule

// File: tb/sim_irq_hub.sv
`timescale 1ns/1ps
module sim_irq_hub;

  localparam int NBANK = 2;
  localparam int NLINE = NBANK * 32;

  logic             clk;
  logic             rst_n;
  logic [NLINE-1:0] line_n;
  logic [9:0]       bus_addr;
  logic             bus_wr;
  logic             bus_rd;
  logic [31:0]      bus_wdata;
  logic [31:0]      bus_rdata;
  logic             irq_o;
  logic             fiq_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  irq_hub #(.NBANK(NBANK)) u0 (
    .clk(clk), .rst_n(rst_n), .line_n(line_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // address[73:64], write data[63:32], expected readback[31:0]
  localparam logic [73:0] VEC [6] = '{
    {10'h01C, 32'hFFFF_FFFF, 32'h0000_007F},
    {10'h098, 32'h0000_0055, 32'h0000_0055},
    {10'h040, 32'h0000_0006, 32'h0000_0006},
    {10'h11C, 32'h0000_007D, 32'h0000_007D},
    {10'h17C, 32'h0000_0081, 32'h0000_0001},
    {10'h0A0, 32'h1234_5678, 32'h0000_0000}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    bus_addr = a;
    bus_rd   = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd   = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    line_n    = '1;
    bus_addr  = '0;
    bus_wdata = '0;
    bus_wr    = 1'b0;
    bus_rd    = 1'b0;
    rst_n     = 1'b0;
    idle(4);
    rst_n = 1'b1;
    idle(2);

    // Reset state
    chk("R1 irq low", 32'(irq_o), 0);
    chk("R1 fiq low", 32'(fiq_o), 0);
    rd(10'h000, v); chk("R1 pending", v, 0);
    rd(10'h004, v); chk("R1 mask bank0", v, 32'hFFFF_FFFF);
    rd(10'h104, v); chk("R1 mask bank1", v, 32'hFFFF_FFFF);
    rd(10'h02C, v); chk("R1 cfg", v, 0);
    rd(10'h010, v); chk("R1 code", v, 0);

    // Configuration word table walk
    for (int k = 0; k < 6; k++) begin
      wr(VEC[k][73:64], VEC[k][63:32]);
      rd(VEC[k][73:64], v);
      chk("R2 R12 cfg readback", v, VEC[k][31:0]);
      wr(VEC[k][73:64], 32'h0);
    end

    // Edge-sensed normal line 3, priority 2
    wr(10'h028, 32'h8);
    line_n[3] = 1'b0;
    idle(3);
    rd(10'h000, v); chk("R3 edge pending", v, 32'h8);
    chk("R6 masked no irq", 32'(irq_o), 0);
    wr(10'h004, ~32'h8);
    idle(2);
    chk("R8 irq fires", 32'(irq_o), 1);
    rd(10'h010, v); chk("R10 irq code", v, 3);
    rd(10'h000, v); chk("R10 edge ack", v, 0);
    idle(3);
    rd(10'h000, v); chk("R3 held low no repend", v, 0);
    chk("R8 irq held", 32'(irq_o), 1);
    wr(10'h018, 32'h2);
    chk("R11 other class bit", 32'(irq_o), 1);
    wr(10'h018, 32'h1);
    chk("R11 drop", 32'(irq_o), 0);
    idle(3);
    chk("R11 stays low", 32'(irq_o), 0);
    line_n[3] = 1'b1;
    idle(2);
    line_n[3] = 1'b0;
    idle(3);
    chk("R3 new assertion", 32'(irq_o), 1);
    rd(10'h010, v); chk("R10 irq code again", v, 3);
    wr(10'h018, 32'h1);
    line_n[3] = 1'b1;
    wr(10'h004, 32'hFFFF_FFFF);
    idle(2);

    // Level-sensed masked line 7
    wr(10'h038, 32'h2);
    line_n[7] = 1'b0;
    idle(3);
    rd(10'h000, v); chk("R4 level pending", v, 32'h80);
    wr(10'h000, 32'h0);
    rd(10'h000, v); chk("R4 clear ignored", v, 32'h80);
    line_n[7] = 1'b1;
    idle(2);
    rd(10'h000, v); chk("R4 deassert clears", v, 0);

    // Software raise and clearing write
    wr(10'h008, 32'h30);
    rd(10'h000, v); chk("R7 soft raise", v, 32'h30);
    rd(10'h008, v); chk("R7 soft reads 0", v, 0);
    wr(10'h000, 32'hFFFF_FFEF);
    rd(10'h000, v); chk("R5 zero clears", v, 32'h20);
    wr(10'h000, 32'h0);
    rd(10'h000, v); chk("R5 all clear", v, 0);

    // Priority order
    wr(10'h044, 32'hC);
    wr(10'h06C, 32'h4);
    wr(10'h080, 32'h4);
    wr(10'h11C, 32'h4);
    wr(10'h004, 32'hFDEF_FBFF);
    wr(10'h104, 32'hFFFF_FFFE);
    wr(10'h108, 32'h1);
    idle(2);
    chk("R8 irq bank1", 32'(irq_o), 1);
    rd(10'h010, v); chk("R9 R12 global line 32", v, 32);
    wr(10'h008, 32'h0210_0400);
    wr(10'h018, 32'h1);
    chk("R11 drop before re-eval", 32'(irq_o), 0);
    idle(2);
    chk("R11 re-eval fires", 32'(irq_o), 1);
    rd(10'h010, v); chk("R9 tie higher line", v, 25);
    wr(10'h018, 32'h1);
    idle(2);
    rd(10'h010, v); chk("R9 next equal prio", v, 20);
    wr(10'h018, 32'h1);
    idle(2);
    rd(10'h010, v); chk("R9 lowest urgency last", v, 10);
    wr(10'h018, 32'h1);
    idle(3);
    chk("R8 nothing left", 32'(irq_o), 0);
    wr(10'h004, 32'hFFFF_FFFF);
    wr(10'h104, 32'hFFFF_FFFF);

    // Fast class, edge and level lines in bank 1
    wr(10'h13C, 32'h1);
    wr(10'h140, 32'h3);
    wr(10'h104, 32'hFFFF_FCFF);
    wr(10'h108, 32'h100);
    idle(2);
    chk("R13 fiq fires", 32'(fiq_o), 1);
    chk("R13 irq quiet", 32'(irq_o), 0);
    rd(10'h014, v); chk("R10 fiq code", v, 40);
    rd(10'h110, v); chk("R12 code only bank0", v, 0);
    line_n[41] = 1'b0;
    idle(2);
    wr(10'h018, 32'h2);
    idle(2);
    chk("R11 fiq rearm fires", 32'(fiq_o), 1);
    rd(10'h014, v); chk("R10 fiq level code", v, 41);
    rd(10'h100, v); chk("R10 level not acked", v, 32'h200);
    line_n[41] = 1'b1;
    idle(2);
    rd(10'h100, v); chk("R4 level released", v, 0);
    rd(10'h304, v); chk("R12 absent bank", v, 0);
    rd(10'h00C, v); chk("R12 undefined offset", v, 0);
    wr(10'h018, 32'h2);
    idle(3);
    chk("R11 fiq low", 32'(fiq_o), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule